// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that counts slow-tick periods on its own, apart from the main program logic. Software reaches it through a small register write port with four addresses: a write-only key register, a 3-bit divider select, a 12-bit reload value and a status word. A 12-bit down-counter steps once every N slow ticks, where N comes from the divider select. When the counter runs out, the block raises a one-cycle reset pulse, reloads itself and keeps counting. The block does not handle the clock crossing itself. The slow clock arrives as a single-cycle enable, `tick`, on the main clock.

All control goes through magic 16-bit values written to the key register. One value starts the counter. One refreshes it from the reload value. One opens the divider and reload registers for writing. Any other key value closes them again. Each accepted configuration write sets a busy flag while the new value is carried into the counting side. That transfer is modelled as a short wait measured in slow ticks.

The counting side has two states, IDLE and COUNT. The only transition is IDLE to COUNT, taken on a start key, and nothing leads back. Each configuration path has two states, SYNC_IDLE and SYNC_BUSY. SYNC_IDLE moves to SYNC_BUSY on an accepted write. SYNC_BUSY returns to SYNC_IDLE on the third slow tick after that write.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `wdt_rst` is low, the block is in IDLE, the divider select reads 0, the reload value reads 0xFFF and the status reads 0.
- R2: Writing 0xCCCC to address 0 moves IDLE to COUNT with the counter at 0xFFF. In IDLE no pulse is ever produced. The first timeout after start comes 4095 x divisor ticks later.
- R3: Writing 0xAAAA to address 0 in COUNT loads the counter with the effective reload value and clears the divider phase. In IDLE this write has no effect.
- R4: Writing 0x5555 to address 0 opens configuration writes. Any other value written to address 0, 0xAAAA and 0xCCCC included, closes them.
- R5: A write to address 1 (divider select, bits [2:0]) or address 2 (reload, bits [11:0]) made while configuration is closed is ignored, and the readback is unchanged.
- R6: Divider select 0 to 5 gives a divisor of 4, 8, 16, 32, 64 and 128. Select 6 and select 7 both give 256.
- R7: With reload value R of at least 1 and divisor D, `wdt_rst` goes high for exactly one clock cycle on the clock after the D*R-th tick that follows a refresh. The counter then reloads and the next pulse follows another D*R ticks later. A refresh made one tick before expiry prevents the pulse.
- R8: Status bit 0 (divider busy) and bit 1 (reload busy) rise on an accepted write. Each falls on the third tick after that write, and the new value takes effect at that same edge.
- R9: A write to address 1 or 2 while its busy bit is set is ignored.
- R10: Address 0 reads as 0x0000. Address 3 reads the busy bits in [1:0] and zero elsewhere.
- R11: Once in COUNT, no key write stops the counter. A further 0xCCCC changes neither the counter nor the divider phase.
- R12: If a refresh is written in the same cycle as the tick that would expire the counter, the refresh wins and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick | input | 1 | One-cycle enable marking each slow-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 divider select, 2 reload, 3 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 16 | Combinational read data |
| wdt_rst | output | 1 | One-cycle timeout reset pulse |

## Verification
The collision that matters is a refresh key write arriving in the same clock as the tick that would take the counter from 1 to expiry. The bench refreshes, issues exactly D*R-1 ticks, and then drives the refresh write and the final tick together in a single cycle. It requires `wdt_rst` to stay low at the following sample and the next pulse to arrive a full D*R ticks later. The behavioural model gives the same priority to refresh and is compared against the outputs on every clock. A second case moves the refresh one tick earlier and gives the same verdict.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    localparam int KEY_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_KEY    = 2'd0,
        ADDR_DIV    = 2'd1,
        ADDR_RELOAD = 2'd2,
        ADDR_STATUS = 2'd3
    } reg_addr_e;

    typedef enum logic {
        RUN_IDLE  = 1'b0,
        RUN_COUNT = 1'b1
    } run_state_e;

    typedef enum logic {
        SYNC_IDLE = 1'b0,
        SYNC_BUSY = 1'b1
    } sync_state_e;

endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode
    import keyed_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_data,
    output logic             start_req,
    output logic             refresh_req,
    output logic             cfg_open
);

    logic open_q;

    assign start_req   = key_wr && (key_data == KEY_START);
    assign refresh_req = key_wr && (key_data == KEY_REFRESH);
    assign cfg_open    = open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (key_wr) begin
            open_q <= (key_data == KEY_OPEN);
        end
    end

    AST_OTHER_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data != KEY_OPEN) |=> !cfg_open); // R4
    AST_OPEN_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data == KEY_OPEN) |=> cfg_open); // R4

endmodule

// File: rtl/wdt_cfg_sync.sv
module wdt_cfg_sync
    import keyed_wdt_pkg::*;
#(
    parameter int             W          = 12,
    parameter logic [W-1:0]   RESET_VAL  = '0,
    parameter int             SYNC_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_req,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] staged,
    output logic [W-1:0] active,
    output logic         busy
);

    localparam int CW = $clog2(SYNC_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

    sync_state_e   state_q, state_d;
    logic [CW-1:0] ticks_q;
    logic [W-1:0]  staged_q, active_q;
    logic          accept, finish;

    assign accept = load_req && (state_q == SYNC_IDLE);
    assign finish = (state_q == SYNC_BUSY) && tick && (ticks_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_IDLE: if (accept) state_d = SYNC_BUSY;
            SYNC_BUSY: if (finish) state_d = SYNC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SYNC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged_q <= RESET_VAL;
            active_q <= RESET_VAL;
            ticks_q  <= '0;
        end else if (accept) begin
            staged_q <= load_data;
            ticks_q  <= '0;
        end else if (finish) begin
            active_q <= staged_q;
        end else if (state_q == SYNC_BUSY && tick) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end

    assign staged = staged_q;
    assign active = active_q;
    assign busy   = (state_q == SYNC_BUSY);

    AST_BUSY_HOLDS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load_req) |=> $stable(staged)); // R9
    AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick)); // R8
    AST_ACTIVE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(active)); // R8

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import keyed_wdt_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_req,
    input  logic             refresh_req,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [CNT_W-1:0] reload,
    output logic             fire
);

    localparam int MAX_SHIFT = 6;
    localparam int PSC_W = 2 + MAX_SHIFT;

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PSC_W-1:0] psc_q, psc_limit;
    logic             fire_q, step;

    // divisor 4 << min(sel, 6), expressed as a terminal phase count
    always_comb begin
        if (div_sel >= SEL_W'(MAX_SHIFT)) psc_limit = '1;
        else psc_limit = PSC_W'((32'd4 << div_sel) - 32'd1);
    end

    assign step = tick && (psc_q >= psc_limit);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_IDLE:  if (start_req) state_d = RUN_COUNT;
            RUN_COUNT: state_d = RUN_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            psc_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            unique case (state_q)
                RUN_IDLE: begin
                    cnt_q <= '1;
                    psc_q <= '0;
                end
                RUN_COUNT: begin
                    if (refresh_req) begin
                        cnt_q <= reload;
                        psc_q <= '0;
                    end else if (step) begin
                        psc_q <= '0;
                        if (cnt_q <= CNT_W'(1)) begin
                            cnt_q  <= reload;
                            fire_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end else if (tick) begin
                        psc_q <= psc_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign fire = fire_q;

    AST_NEVER_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_COUNT) |=> (state_q == RUN_COUNT)); // R11
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R7
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_IDLE) |=> !fire); // R2
    AST_REFRESH_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_COUNT && refresh_req) |=> !fire); // R12

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import keyed_wdt_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int SEL_W      = 3,
    parameter int SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [KEY_W-1:0]  rd_data,
    output logic              wdt_rst
);

    logic             key_wr, start_req, refresh_req, cfg_open;
    logic             div_load, rel_load, div_busy, rel_busy;
    logic [SEL_W-1:0] div_staged, div_active;
    logic [CNT_W-1:0] rel_staged, rel_active;

    assign key_wr   = wr_en && (reg_addr_e'(wr_addr) == ADDR_KEY);
    assign div_load = wr_en && (reg_addr_e'(wr_addr) == ADDR_DIV) && cfg_open;
    assign rel_load = wr_en && (reg_addr_e'(wr_addr) == ADDR_RELOAD) && cfg_open;

    wdt_key_decode u_keys (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_wr      (key_wr),
        .key_data    (wr_data),
        .start_req   (start_req),
        .refresh_req (refresh_req),
        .cfg_open    (cfg_open)
    );

    wdt_cfg_sync #(.W(SEL_W), .RESET_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_div_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load_req  (div_load),
        .load_data (wr_data[SEL_W-1:0]),
        .staged    (div_staged),
        .active    (div_active),
        .busy      (div_busy)
    );

    wdt_cfg_sync #(.W(CNT_W), .RESET_VAL('1), .SYNC_TICKS(SYNC_TICKS)) u_rel_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load_req  (rel_load),
        .load_data (wr_data[CNT_W-1:0]),
        .staged    (rel_staged),
        .active    (rel_active),
        .busy      (rel_busy)
    );

    wdt_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start_req   (start_req),
        .refresh_req (refresh_req),
        .div_sel     (div_active),
        .reload      (rel_active),
        .fire        (wdt_rst)
    );

    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(rd_addr))
            ADDR_KEY:    rd_data = '0;
            ADDR_DIV:    rd_data = KEY_W'(div_staged);
            ADDR_RELOAD: rd_data = KEY_W'(rel_staged);
            ADDR_STATUS: rd_data = KEY_W'({rel_busy, div_busy});
        endcase
    end

    AST_CLOSED_DIV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr_e'(wr_addr) == ADDR_DIV && !cfg_open) |=> $stable(div_staged)); // R5
    AST_CLOSED_REL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr_e'(wr_addr) == ADDR_RELOAD && !cfg_open) |=> $stable(rel_staged)); // R5
    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_e'(rd_addr) == ADDR_KEY) |-> (rd_data == '0)); // R10

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

    logic        clk = 1'b0;
    logic        rst_n, tick, wr_en, wdt_rst, rd_auto;
    logic [1:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    int m_run, m_cnt, m_psc, m_open, m_fire;
    int m_ds, m_da, m_db, m_dn, m_rs, m_ra, m_rb, m_rn;

    always #5 clk = ~clk;

    keyed_watchdog u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wdt_rst (wdt_rst)
    );

    function automatic int divisor(int sel);
        return 4 * (1 << ((sel > 6) ? 6 : sel));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 4095; m_psc = 0; m_open = 0; m_fire = 0;
            m_ds = 0; m_da = 0; m_db = 0; m_dn = 0;
            m_rs = 4095; m_ra = 4095; m_rb = 0; m_rn = 0;
        end else begin
            bit is_key;
            is_key = wr_en && wr_addr == 2'd0;
            m_fire = 0;
            if (m_run == 0) begin
                if (is_key && wr_data == 16'hCCCC) m_run = 1;
            end else if (is_key && wr_data == 16'hAAAA) begin
                m_cnt = m_ra; m_psc = 0;
            end else if (tick) begin
                m_psc++;
                if (m_psc == divisor(m_da) || m_psc > divisor(m_da)) begin
                    m_psc = 0;
                    if (m_cnt > 1) m_cnt--;
                    else begin m_cnt = m_ra; m_fire = 1; end
                end
            end
            if (wr_en && wr_addr == 2'd1 && m_open == 1 && m_db == 0) begin
                m_ds = int'(wr_data[2:0]); m_db = 1; m_dn = 0;
            end else if (m_db == 1 && tick) begin
                m_dn++;
                if (m_dn == 3) begin m_da = m_ds; m_db = 0; end
            end
            if (wr_en && wr_addr == 2'd2 && m_open == 1 && m_rb == 0) begin
                m_rs = int'(wr_data[11:0]); m_rb = 1; m_rn = 0;
            end else if (m_rb == 1 && tick) begin
                m_rn++;
                if (m_rn == 3) begin m_ra = m_rs; m_rb = 0; end
            end
            if (is_key) m_open = (wr_data == 16'h5555) ? 1 : 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            int exp_rd;
            case (rd_addr)
                2'd0: exp_rd = 0;
                2'd1: exp_rd = m_ds;
                2'd2: exp_rd = m_rs;
                default: exp_rd = m_rb * 2 + m_db;
            endcase
            n_cmp++;
            if (int'(wdt_rst) != m_fire) begin
                n_bad++;
                $display("FAIL R7 wdt_rst actual %0d expected %0d at %0t", wdt_rst, m_fire, $time);
            end
            n_cmp++;
            if (int'(rd_data) != exp_rd) begin
                n_bad++;
                $display("FAIL R10 rd_data@%0d actual %0h expected %0h at %0t", rd_addr, rd_data, exp_rd, $time);
            end
            if (rd_auto) rd_addr = rd_addr + 2'd1;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d, input bit t);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d); tick = t;
        @(posedge clk); #1;
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(posedge clk); #1;
        rd_auto = 1'b0; rd_addr = 2'(a);
        @(negedge clk);
        v = int'(rd_data);
        rd_auto = 1'b1;
    endtask

    task automatic tick_one(input int gap, output bit hit);
        @(posedge clk); #1 tick = 1'b1;
        @(posedge clk); #1 tick = 1'b0;
        @(negedge clk);
        hit = wdt_rst;
        repeat (gap) @(posedge clk);
    endtask

    task automatic to_pulse(input int gap, output int n);
        bit hit;
        hit = 1'b0; n = 0;
        while (!hit && n < 20000) begin
            tick_one(gap, hit);
            n++;
        end
    endtask

    task automatic quiet_ticks(input int cnt, output int hits);
        bit hit;
        hits = 0;
        for (int i = 0; i < cnt; i++) begin
            tick_one(0, hit);
            hits += int'(hit);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int v, n, h;
        tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; rd_auto = 1; rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        @(negedge clk) chk("R1 wdt_rst after reset", int'(wdt_rst), 0);
        rd(0, v); chk("R10 key readback", v, 0);
        rd(1, v); chk("R1 divider reset", v, 0);
        rd(2, v); chk("R1 reload reset", v, 4095);
        rd(3, v); chk("R1 status reset", v, 0);
        quiet_ticks(40, h); chk("R2 idle gives no pulse", h, 0);

        wr(1, 5, 0); rd(1, v); chk("R5 closed divider write", v, 0);
        wr(2, 7, 0); rd(2, v); chk("R5 closed reload write", v, 4095);

        wr(0, 16'hCCCC, 0); to_pulse(0, n); chk("R2 first timeout ticks", n, 4 * 4095);
        @(negedge clk) chk("R7 pulse lasts one cycle", int'(wdt_rst), 0);

        quiet_ticks(100, h);
        wr(0, 16'hCCCC, 0); to_pulse(0, n); chk("R11 second start ignored", n, 4 * 4095 - 100);

        wr(0, 16'h5555, 0); wr(1, 1, 0);
        rd(3, v); chk("R8 divider busy set", v, 1);
        wr(1, 2, 0); rd(1, v); chk("R9 write while busy ignored", v, 1);
        quiet_ticks(2, h); rd(3, v); chk("R8 busy after two ticks", v, 1);
        quiet_ticks(1, h); rd(3, v); chk("R8 busy cleared on third tick", v, 0);
        wr(2, 5, 0); rd(3, v); chk("R8 reload busy set", v, 2);
        quiet_ticks(3, h);
        wr(0, 16'h1234, 0); wr(2, 9, 0); rd(2, v); chk("R4 other key closes", v, 5);

        wr(0, 16'hAAAA, 0); to_pulse(0, n); chk("R3 refresh then timeout /8 x5", n, 40);
        to_pulse(2, n); chk("R7 reloads and repeats", n, 40);

        wr(0, 16'hAAAA, 0); quiet_ticks(39, h); chk("R7 no pulse before expiry", h, 0);
        wr(0, 16'hAAAA, 0); to_pulse(0, n); chk("R7 refresh one tick early", n, 40);

        wr(0, 16'hAAAA, 0); quiet_ticks(39, h);
        wr(0, 16'hAAAA, 1);
        @(negedge clk) chk("R12 refresh beats expiry tick", int'(wdt_rst), 0);
        to_pulse(0, n); chk("R12 full period after collision", n, 40);

        wr(0, 16'h5555, 0); wr(1, 7, 0); wr(2, 1, 0); quiet_ticks(3, h);
        wr(0, 16'hAAAA, 0); to_pulse(1, n); chk("R6 select 7 divides by 256", n, 256);
        wr(0, 16'h5555, 0); wr(1, 6, 0); quiet_ticks(3, h);
        wr(0, 16'hAAAA, 0); to_pulse(0, n); chk("R6 select 6 divides by 256", n, 256);
        wr(0, 16'h5555, 0); wr(1, 0, 0); wr(2, 3, 0); quiet_ticks(3, h);
        wr(0, 16'hAAAA, 0); to_pulse(2, n); chk("R6 select 0 divides by 4", n, 12);

        repeat (4) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule